// File: doc/BRIEF.md
# Transmit descriptor ring reader

This block walks a ring of two-word transmit descriptors held in a descriptor memory. For each descriptor it reads the buffer pointer and the control word, then reads that many bytes from a byte-wide data memory and presents them on a valid/ready byte stream. A frame may span several descriptors. The last byte of a frame carries an end marker, and it also carries a flag that asks the downstream MAC not to append a frame check sequence. When a buffer is finished, the block rewrites the control word with the ownership bit set, which hands the descriptor back to software. Both memories are read combinationally: the address goes out and the read data comes back in the same cycle.

Software queues a buffer by clearing the ownership bit in its control word, then pulses start. The engine runs until it finds a descriptor that it owns. It also stops when a halt request has been raised and the frame in flight has ended. The transmit-go output is high for the whole time the engine runs. Two sticky error flags are cleared by the next start. One reports a stalled downstream side (underrun). The other reports that the ring ran dry in the middle of a frame.

Top module: `tdq_tx_reader`

## Requirements
- R1: A start pulse while idle raises tx_go_o on the next cycle. tx_go_o stays high until the engine stops. A start pulse while running has no effect.
- R2: Word 0 of a descriptor (at base + 2·index) is the byte address of its buffer. Bits 10:0 of word 1 give the number of bytes, and these bytes are streamed in address order.
- R3: Bit 15 of the control word marks the buffer that ends the frame. tx_last_o is high only on that buffer's final byte. Bit 16 is copied to tx_nocrc_o on that same beat and is low on every other beat.
- R4: Once the final byte of a buffer has been accepted, the control word is written back with bit 31 set and all other bits unchanged. Before that acceptance, bit 31 in memory stays clear.
- R5: After a descriptor with bit 30 set, the next descriptor is fetched at the queue base. Later slots are not read.
- R6: If bit 31 is set in a descriptor at a frame boundary, the engine stops with its pointer on that descriptor. The next start resumes there.
- R7: If bit 31 is set in a descriptor that continues a frame, the engine sends one beat with tx_err_o and tx_last_o high and data 0. It writes bit 27 into that descriptor's control word, sets err_exhausted_o and stops.
- R8: The engine declares an underrun when a byte has waited with ready low for stall_limit_i cycles and ready is still low in the next cycle. It then drops the beat, writes back bits 31 and 28, advances the pointer, sets err_underrun_o and stops. A limit of 0 turns this check off.
- R9: While a byte waits with ready low, tx_valid_o stays high and the beat (buffer address and data) stays unchanged.
- R10: A halt request lets the frame in flight finish and then stops the engine before the next frame. The next queued descriptor is left untouched.
- R11: After reset the engine is idle. Its pointer is at the queue base, no beat or write is issued, and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| halt_i | input | 1 | Halt request pulse |
| base_i | input | ADDR_W | Queue base, word address of descriptor 0 |
| stall_limit_i | input | STALL_W | Tolerated ready-low cycles per byte, 0 disables the check |
| desc_addr_o | output | ADDR_W | Descriptor memory word address |
| desc_rdata_i | input | 32 | Descriptor memory read data (same cycle) |
| desc_we_o | output | 1 | Descriptor write-back strobe |
| desc_wdata_o | output | 32 | Descriptor write-back data |
| buf_addr_o | output | 32 | Data memory byte address |
| buf_rdata_i | input | 8 | Data memory read data (same cycle) |
| tx_valid_o | output | 1 | Stream beat valid |
| tx_ready_i | input | 1 | Stream beat accepted |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final beat of a frame |
| tx_nocrc_o | output | 1 | Frame must not get an appended check sequence |
| tx_err_o | output | 1 | Frame aborted (ring exhausted) |
| tx_go_o | output | 1 | Engine running |
| err_underrun_o | output | 1 | Sticky underrun flag |
| err_exhausted_o | output | 1 | Sticky exhausted-mid-frame flag |

## Verification
Two events can meet in one cycle: the stall timer reaching its limit, and the downstream side accepting the waiting byte. One test holds ready low for exactly the tolerated cycles and raises it in the cycle where the count has reached the limit. The byte must be delivered, no underrun may be flagged, and the write-back must carry bit 31 without bit 28. A second test keeps ready low one cycle longer and expects the underrun path.

// File: rtl/tdq_pkg.sv
package tdq_pkg;
   localparam int LEN_W   = 11;
   localparam int EOF_B   = 15;
   localparam int NOCRC_B = 16;
   localparam int EXH_B   = 27;
   localparam int UNDR_B  = 28;
   localparam int WRAP_B  = 30;
   localparam int USED_B  = 31;

   localparam logic [31:0] USED_M = 32'h1 << USED_B;
   localparam logic [31:0] UNDR_M = 32'h1 << UNDR_B;
   localparam logic [31:0] EXH_M  = 32'h1 << EXH_B;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_ADDR,
      ST_SEND,
      ST_WB,
      ST_EXH
   } tdq_state_e;
endpackage

// File: rtl/tdq_ring_ptr.sv
module tdq_ring_ptr #(
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              advance_i,
   input  logic              wrap_i,
   output logic [ADDR_W-1:0] ptr_addr_o,
   output logic [ADDR_W-1:0] stat_addr_o
);
   if (IDX_W < 1 || ADDR_W <= IDX_W) begin : g_bad_cfg
      $error("tdq_ring_ptr: ADDR_W must exceed IDX_W and IDX_W must be positive");
   end

   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] slot_off;

   assign slot_off    = ADDR_W'({idx_q, 1'b0});
   assign ptr_addr_o  = base_i + slot_off;
   assign stat_addr_o = base_i + slot_off + ADDR_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)         idx_q <= '0;
      else if (advance_i) idx_q <= wrap_i ? '0 : idx_q + IDX_W'(1);
   end

   assert_wrap_to_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (advance_i && wrap_i) |=> (ptr_addr_o == $past(base_i)));
endmodule

// File: rtl/tdq_stall_timer.sv
module tdq_stall_timer #(
   parameter int CNT_W  = 8,
   parameter bit ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active_i,
   input  logic             ready_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             expire_o
);
   if (CNT_W < 1) begin : g_bad_cfg
      $error("tdq_stall_timer: CNT_W must be positive");
   end

   if (ENABLE) begin : g_on
      logic [CNT_W-1:0] cnt_q;
      logic             stalled;

      assign stalled  = active_i && !ready_i;
      assign expire_o = stalled && (limit_i != '0) && (cnt_q >= limit_i);

      always_ff @(posedge clk) begin
         if (!rst_n)                    cnt_q <= '0;
         else if (!stalled || expire_o) cnt_q <= '0;
         else if (cnt_q != '1)          cnt_q <= cnt_q + CNT_W'(1);
      end

      assert_expire_after_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
         expire_o |-> $past(active_i && !ready_i));
   end else begin : g_off
      assign expire_o = 1'b0;
   end
endmodule

// File: rtl/tdq_tx_reader.sv
module tdq_tx_reader
   import tdq_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int IDX_W    = 4,
   parameter int STALL_W  = 8,
   parameter bit STALL_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               halt_i,
   input  logic [ADDR_W-1:0]  base_i,
   input  logic [STALL_W-1:0] stall_limit_i,
   output logic [ADDR_W-1:0]  desc_addr_o,
   input  logic [31:0]        desc_rdata_i,
   output logic               desc_we_o,
   output logic [31:0]        desc_wdata_o,
   output logic [31:0]        buf_addr_o,
   input  logic [7:0]         buf_rdata_i,
   output logic               tx_valid_o,
   input  logic               tx_ready_i,
   output logic [7:0]         tx_data_o,
   output logic               tx_last_o,
   output logic               tx_nocrc_o,
   output logic               tx_err_o,
   output logic               tx_go_o,
   output logic               err_underrun_o,
   output logic               err_exhausted_o
);
   tdq_state_e        state_q;
   logic [31:0]       ctrl_q;
   logic [31:0]       baddr_q;
   logic [LEN_W-1:0]  off_q;
   logic              in_frame_q;
   logic              halt_q;
   logic              err_u_q;
   logic              err_x_q;
   logic              advance;
   logic              stall_hit;
   logic              last_byte;
   logic              frame_end;
   logic [ADDR_W-1:0] ptr_addr;
   logic [ADDR_W-1:0] stat_addr;

   tdq_ring_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .base_i     (base_i),
      .advance_i  (advance),
      .wrap_i     (ctrl_q[WRAP_B]),
      .ptr_addr_o (ptr_addr),
      .stat_addr_o(stat_addr)
   );

   tdq_stall_timer #(.CNT_W(STALL_W), .ENABLE(STALL_EN)) u_stall (
      .clk     (clk),
      .rst_n   (rst_n),
      .active_i(state_q == ST_SEND),
      .ready_i (tx_ready_i),
      .limit_i (stall_limit_i),
      .expire_o(stall_hit)
   );

   assign last_byte  = (off_q == (ctrl_q[LEN_W-1:0] - LEN_W'(1)));
   assign frame_end  = (state_q == ST_SEND) && last_byte && ctrl_q[EOF_B];

   assign desc_addr_o = (state_q == ST_ADDR) ? ptr_addr : stat_addr;
   assign buf_addr_o  = baddr_q + 32'(off_q);
   assign tx_valid_o  = (state_q == ST_SEND) || (state_q == ST_EXH);
   assign tx_data_o   = (state_q == ST_EXH) ? 8'h00 : buf_rdata_i;
   assign tx_last_o   = frame_end || (state_q == ST_EXH);
   assign tx_nocrc_o  = frame_end && ctrl_q[NOCRC_B];
   assign tx_err_o    = (state_q == ST_EXH);
   assign tx_go_o     = (state_q != ST_IDLE);
   assign err_underrun_o  = err_u_q;
   assign err_exhausted_o = err_x_q;

   always_comb begin
      desc_we_o    = 1'b0;
      desc_wdata_o = ctrl_q;
      advance      = 1'b0;
      unique case (state_q)
         ST_WB: begin
            desc_we_o    = 1'b1;
            desc_wdata_o = ctrl_q | USED_M;
            advance      = 1'b1;
         end
         ST_SEND: if (stall_hit) begin
            desc_we_o    = 1'b1;
            desc_wdata_o = ctrl_q | USED_M | UNDR_M;
            advance      = 1'b1;
         end
         ST_EXH: if (tx_ready_i) begin
            desc_we_o    = 1'b1;
            desc_wdata_o = ctrl_q | EXH_M;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         ctrl_q     <= '0;
         baddr_q    <= '0;
         off_q      <= '0;
         in_frame_q <= 1'b0;
         halt_q     <= 1'b0;
         err_u_q    <= 1'b0;
         err_x_q    <= 1'b0;
      end else begin
         if (halt_i && state_q != ST_IDLE) halt_q <= 1'b1;
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               state_q <= ST_CTRL;
               err_u_q <= 1'b0;
               err_x_q <= 1'b0;
               halt_q  <= 1'b0;
            end
            ST_CTRL: begin
               ctrl_q <= desc_rdata_i;
               if (!in_frame_q && halt_q) begin
                  state_q <= ST_IDLE;
                  halt_q  <= 1'b0;
               end else if (desc_rdata_i[USED_B]) begin
                  state_q <= in_frame_q ? ST_EXH : ST_IDLE;
                  if (!in_frame_q) halt_q <= 1'b0;
               end else begin
                  state_q <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               baddr_q <= desc_rdata_i;
               off_q   <= '0;
               state_q <= (ctrl_q[LEN_W-1:0] == '0) ? ST_WB : ST_SEND;
            end
            ST_SEND: begin
               if (stall_hit) begin
                  state_q    <= ST_IDLE;
                  err_u_q    <= 1'b1;
                  in_frame_q <= 1'b0;
                  halt_q     <= 1'b0;
               end else if (tx_ready_i) begin
                  if (last_byte) state_q <= ST_WB;
                  else           off_q   <= off_q + LEN_W'(1);
               end
            end
            ST_WB: begin
               in_frame_q <= !ctrl_q[EOF_B];
               state_q    <= ST_CTRL;
            end
            ST_EXH: if (tx_ready_i) begin
               state_q    <= ST_IDLE;
               err_x_q    <= 1'b1;
               in_frame_q <= 1'b0;
               halt_q     <= 1'b0;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assert_wb_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      desc_we_o |-> desc_wdata_o[USED_B]);

   assert_wb_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WB) |->
         ($past(state_q == ST_SEND && tx_ready_i && last_byte) || $past(state_q == ST_ADDR)));

   assert_nocrc_on_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_nocrc_o |-> (tx_last_o && tx_valid_o && !tx_err_o));

   assert_beat_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SEND && !tx_ready_i) |=>
         ((tx_valid_o && $stable(buf_addr_o)) || err_underrun_o));

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_go_o |-> (!tx_valid_o && !desc_we_o));

   assert_single_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_exhausted_o) |-> ($past(tx_err_o && tx_ready_i) && !tx_go_o));
endmodule

// File: tb/tb_tdq_tx_reader.sv
module tb_tdq_tx_reader;
   localparam int BASE = 16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i, halt_i;
   logic [7:0]  base_i;
   logic [7:0]  stall_limit_i;
   logic [7:0]  desc_addr;
   logic [31:0] desc_rdata;
   logic        desc_we;
   logic [31:0] desc_wdata;
   logic [31:0] buf_addr;
   logic [7:0]  buf_rdata;
   logic        tx_valid, tx_ready, tx_last, tx_nocrc, tx_err, tx_go;
   logic [7:0]  tx_data;
   logic        err_u, err_x;

   logic [31:0] dmem [0:255];
   logic [7:0]  bmem [0:1023];
   logic [7:0]  cap_data [0:255];
   logic        cap_last [0:255];
   logic        cap_nocrc [0:255];
   logic        cap_err [0:255];
   int          cap_n = 0;
   int          checks = 0;
   int          fails = 0;

   always #2 clk = ~clk;

   tdq_tx_reader dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .halt_i(halt_i),
      .base_i(base_i), .stall_limit_i(stall_limit_i),
      .desc_addr_o(desc_addr), .desc_rdata_i(desc_rdata),
      .desc_we_o(desc_we), .desc_wdata_o(desc_wdata),
      .buf_addr_o(buf_addr), .buf_rdata_i(buf_rdata),
      .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
      .tx_last_o(tx_last), .tx_nocrc_o(tx_nocrc), .tx_err_o(tx_err),
      .tx_go_o(tx_go), .err_underrun_o(err_u), .err_exhausted_o(err_x)
   );

   assign desc_rdata = dmem[desc_addr];
   assign buf_rdata  = bmem[buf_addr[9:0]];

   always @(posedge clk) begin
      if (desc_we) dmem[desc_addr] <= desc_wdata;
      if (tx_valid && tx_ready) begin
         cap_data[cap_n]  <= tx_data;
         cap_last[cap_n]  <= tx_last;
         cap_nocrc[cap_n] <= tx_nocrc;
         cap_err[cap_n]   <= tx_err;
         cap_n            <= cap_n + 1;
      end
   end

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 13) + 5);
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; start_i = 1'b0; halt_i = 1'b0; tx_ready = 1'b1;
      stall_limit_i = 8'd0; base_i = 8'(BASE);
      for (int i = 0; i < 256; i++) dmem[i] = (i % 2 == 1) ? 32'h8000_0000 : 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic set_desc(input int idx, input int addr, input logic [31:0] ctrl);
      dmem[BASE + 2*idx]     = 32'(addr);
      dmem[BASE + 2*idx + 1] = ctrl;
   endtask

   task automatic pulse_start();
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      int n = 0;
      while (tx_go && n < 1000) begin
         @(negedge clk);
         n++;
      end
      chk(n < 1000, {req, " engine stops"}, n, 0);
   endtask

   task automatic chk_bytes(input string req, input int first, input int addr, input int n);
      for (int i = 0; i < n; i++)
         chk(cap_data[first+i] == pat(addr+i), req, cap_data[first+i], pat(addr+i));
   endtask

   task automatic t_reset();
      do_reset();
      chk(!tx_go && !tx_valid && !desc_we, "R11 idle after reset", {tx_go, tx_valid, desc_we}, 0);
      chk(!err_u && !err_x, "R11 flags clear", {err_u, err_x}, 0);
      chk(desc_addr == 8'(BASE + 1), "R11 pointer at base", desc_addr, BASE + 1);
   endtask

   task automatic t_single();
      int c0;
      do_reset();
      set_desc(0, 100, 32'h0000_8005);
      c0 = cap_n;
      pulse_start();
      chk(tx_go == 1'b1, "R1 tx_go raised", tx_go, 1);
      wait_idle("R1");
      chk(tx_go == 1'b0, "R1 tx_go low after stop", tx_go, 0);
      chk(cap_n - c0 == 5, "R2 byte count", cap_n - c0, 5);
      chk_bytes("R2 byte value", c0, 100, 5);
      chk(cap_last[c0+4] && !cap_last[c0+3], "R3 last on final byte", {cap_last[c0+3], cap_last[c0+4]}, 1);
      chk(!cap_nocrc[c0+4], "R3 nocrc clear", cap_nocrc[c0+4], 0);
      chk(dmem[BASE+1] == 32'h8000_8005, "R4 write-back", dmem[BASE+1], 32'h8000_8005);
      chk(dmem[BASE+3] == 32'h8000_0000, "R6 owned slot untouched", dmem[BASE+3], 32'h8000_0000);
   endtask

   task automatic t_multi();
      int c0;
      do_reset();
      set_desc(0, 200, 32'h0000_0003);
      set_desc(1, 300, 32'h0001_8002);
      c0 = cap_n;
      pulse_start();
      wait_idle("R3");
      chk(cap_n - c0 == 5, "R2 multi-buffer count", cap_n - c0, 5);
      chk_bytes("R2 first buffer", c0, 200, 3);
      chk_bytes("R2 second buffer", c0 + 3, 300, 2);
      chk(!cap_last[c0+2] && !cap_nocrc[c0+2], "R3 no marks mid-frame", {cap_last[c0+2], cap_nocrc[c0+2]}, 0);
      chk(cap_last[c0+4] && cap_nocrc[c0+4], "R3 last and nocrc", {cap_last[c0+4], cap_nocrc[c0+4]}, 3);
      chk(dmem[BASE+1] == 32'h8000_0003, "R4 first write-back", dmem[BASE+1], 32'h8000_0003);
      chk(dmem[BASE+3] == 32'h8001_8002, "R4 second write-back", dmem[BASE+3], 32'h8001_8002);
   endtask

   task automatic t_wrap();
      int c0;
      do_reset();
      set_desc(0, 400, 32'h4000_8002);
      set_desc(1, 500, 32'h0000_8004);
      c0 = cap_n;
      pulse_start();
      wait_idle("R5");
      chk(cap_n - c0 == 2, "R5 slot after wrap not sent", cap_n - c0, 2);
      chk(dmem[BASE+1] == 32'hC000_8002, "R5 wrap descriptor written", dmem[BASE+1], 32'hC000_8002);
      set_desc(0, 410, 32'h4000_8002);
      c0 = cap_n;
      pulse_start();
      wait_idle("R5");
      chk(cap_n - c0 == 2, "R5 refetch at base count", cap_n - c0, 2);
      chk_bytes("R5 refetch at base data", c0, 410, 2);
      chk(dmem[BASE+3] == 32'h0000_8004, "R5 slot 1 untouched", dmem[BASE+3], 32'h0000_8004);
   endtask

   task automatic t_resume();
      int c0;
      do_reset();
      set_desc(0, 50, 32'h0000_8001);
      pulse_start();
      wait_idle("R6");
      set_desc(1, 600, 32'h0000_8002);
      c0 = cap_n;
      pulse_start();
      wait_idle("R6");
      chk(cap_n - c0 == 2, "R6 resume count", cap_n - c0, 2);
      chk_bytes("R6 resume data", c0, 600, 2);
      chk(dmem[BASE+3] == 32'h8000_8002, "R6 resumed slot written", dmem[BASE+3], 32'h8000_8002);
      chk(dmem[BASE+1] == 32'h8000_8001, "R6 earlier slot unchanged", dmem[BASE+1], 32'h8000_8001);
   endtask

   task automatic t_exhaust();
      int c0;
      do_reset();
      set_desc(0, 700, 32'h0000_0002);
      c0 = cap_n;
      pulse_start();
      wait_idle("R7");
      chk(cap_n - c0 == 3, "R7 beats", cap_n - c0, 3);
      chk_bytes("R7 data before abort", c0, 700, 2);
      chk(cap_err[c0+2] && cap_last[c0+2] && cap_data[c0+2] == 8'h00, "R7 error beat",
          {cap_err[c0+2], cap_last[c0+2], cap_data[c0+2]}, 12'h300);
      chk(!cap_last[c0+1], "R7 no early last", cap_last[c0+1], 0);
      chk(err_x && !err_u, "R7 flags", {err_x, err_u}, 2);
      chk(dmem[BASE+3] == 32'h8800_0000, "R7 status bit 27", dmem[BASE+3], 32'h8800_0000);
      chk(dmem[BASE+1] == 32'h8000_0002, "R7 first buffer returned", dmem[BASE+1], 32'h8000_0002);
   endtask

   task automatic t_underrun();
      int c0;
      do_reset();
      stall_limit_i = 8'd3;
      tx_ready = 1'b0;
      set_desc(0, 800, 32'h0000_8004);
      c0 = cap_n;
      pulse_start();
      wait_idle("R8");
      chk(cap_n == c0, "R8 no byte delivered", cap_n - c0, 0);
      chk(err_u && !err_x, "R8 underrun flag", {err_u, err_x}, 2);
      chk(dmem[BASE+1] == 32'h9000_8004, "R8 status bit 28", dmem[BASE+1], 32'h9000_8004);
      tx_ready = 1'b1;
   endtask

   task automatic t_edge_stall();
      int c0;
      int n = 0;
      logic [7:0] held;
      do_reset();
      stall_limit_i = 8'd3;
      tx_ready = 1'b0;
      set_desc(0, 900, 32'h0000_8001);
      c0 = cap_n;
      pulse_start();
      while (!tx_valid && n < 20) begin
         @(negedge clk);
         n++;
      end
      held = tx_data;
      chk(tx_valid && held == pat(900), "R2 pending byte", held, pat(900));
      chk(dmem[BASE+1][31] == 1'b0, "R4 not returned before accept", dmem[BASE+1], 32'h0000_8001);
      repeat (2) begin
         @(negedge clk);
         chk(tx_valid && tx_data == held && tx_last, "R9 beat held", tx_data, held);
      end
      @(negedge clk);
      tx_ready = 1'b1;
      wait_idle("R8");
      chk(cap_n - c0 == 1, "R8 accepted at limit", cap_n - c0, 1);
      chk(!err_u, "R8 no underrun at limit", err_u, 0);
      chk(dmem[BASE+1] == 32'h8000_8001, "R4 returned after accept", dmem[BASE+1], 32'h8000_8001);
   endtask

   task automatic t_halt();
      int c0;
      do_reset();
      set_desc(0, 20, 32'h0000_8003);
      set_desc(1, 40, 32'h0000_8002);
      c0 = cap_n;
      pulse_start();
      halt_i = 1'b1;
      @(negedge clk);
      halt_i = 1'b0;
      wait_idle("R10");
      chk(cap_n - c0 == 3, "R10 current frame finished", cap_n - c0, 3);
      chk(dmem[BASE+3] == 32'h0000_8002, "R10 next frame untouched", dmem[BASE+3], 32'h0000_8002);
      c0 = cap_n;
      pulse_start();
      wait_idle("R10");
      chk(cap_n - c0 == 2, "R10 restart sends next frame", cap_n - c0, 2);
      chk_bytes("R10 restart data", c0, 40, 2);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) bmem[i] = pat(i);
      t_reset();
      t_single();
      t_multi();
      t_wrap();
      t_resume();
      t_exhaust();
      t_underrun();
      t_edge_stall();
      t_halt();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule